// File: doc/BRIEF.md
# TDM Serial Audio Streamer with Byte FIFO

The block takes sample bytes from a host over an 8-bit parallel bus and buffers them in an on-chip FIFO. Once enough bytes are stored, it streams them out as a time-division-multiplexed serial frame toward a sigma-delta DAC. The outputs are a bit clock, a one-bit frame sync and a serial data line. Each frame holds eight 24-bit channel slots. Every slot is built from three consecutive host bytes.

The bit clock is made inside the core clock domain. A half-period counter toggles it, and a select input picks one of two even divide ratios. With the defaults and a 100 MHz core clock, the ratios are divide by 2 (50 MHz, enough for eight 24-bit channels at 192 kHz) and divide by 4. The host writes a burst of bytes for each sample set. The FIFO absorbs the burst, and the streamer fills slots only when a whole slot's worth of bytes is present. Shortfalls and dropped writes are reported on sticky flags that the host clears with a pulse.

Top module: `tdm_dac_streamer`

## Requirements
- R1: After synchronous reset, bclk, fsync, sdata, underflow and overflow are all 0 and the FIFO is empty.
- R2: One byte is stored for each rising edge of wr_stb, taken from wr_data in the cycle the strobe is first seen high. A strobe held high for several cycles stores one byte.
- R3: bclk stays low and fsync and sdata stay 0 until the stored byte count reaches start_lvl. Streaming then starts and continues until reset.
- R4: The bit clock period is 2*HALF_FAST core cycles when div_sel is 0 and 2*HALF_SLOW when div_sel is 1. The defaults give 2 and 4.
- R5: A frame is 192 bit periods (8 slots of 24 bits). fsync is 1 for exactly one bit period, the one just before the MSB of slot 0. While streaming runs, that period is the last bit of the previous frame.
- R6: Slot k of a frame carries three consecutive FIFO bytes, the first byte in bits 23..16. Bits go out MSB first, and slots 0 to 7 take bytes in write order.
- R7: sdata and fsync change only together with a falling bclk edge, so they are stable while bclk is high.
- R8: If fewer than 3 bytes are stored when a slot begins, that slot and the rest of the frame are sent as zeros and those bytes stay in the FIFO. underflow is set once when such a shortage begins.
- R9: After a shortage, data resumes at the first frame boundary where at least 3 bytes are stored, starting in slot 0.
- R10: A write while the FIFO holds DEPTH bytes is dropped and sets the sticky overflow flag. Fullness is judged before any read in that cycle.
- R11: A flag_clr pulse clears both flags. If a flag's set event falls in the same cycle, the flag stays set.
- R12: A reset during streaming returns all outputs to the R1 state and re-arms the start threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 8 | Host byte |
| wr_stb | input | 1 | Host write strobe, rising edge stores a byte |
| start_lvl | input | $clog2(DEPTH+1) | Byte count that starts streaming (typically 100) |
| div_sel | input | 1 | 0 selects the fast bit clock ratio, 1 the slow one |
| flag_clr | input | 1 | Clears both sticky flags |
| bclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync, one bit period wide |
| sdata | output | 1 | Serial data, MSB first |
| underflow | output | 1 | Sticky slot-shortage flag |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
A flag clear can land in the same cycle as the event that sets the flag. The case that matters most is a clear that arrives together with a write into a full FIFO. The bench provokes it by holding the streamer idle with a threshold above the FIFO depth, filling the FIFO, and then raising wr_stb and flag_clr at the same negative clock edge. The result is judged on the overflow port one cycle later: it must read 1. The stream that follows must also show that the colliding byte never entered a slot.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int BYTE_W     = 8;
    localparam int SLOTS      = 8;
    localparam int SLOT_BYTES = 3;
    localparam int SLOT_IW    = $clog2(SLOTS);
    localparam int BYTE_IW    = $clog2(SLOT_BYTES);
    localparam int BIT_IW     = $clog2(BYTE_W);

    typedef enum logic {SER_IDLE, SER_RUN} ser_state_t;

    typedef struct packed {
        logic [SLOT_IW-1:0] slot_i;
        logic [BYTE_IW-1:0] byte_i;
        logic [BIT_IW-1:0]  bit_i;
    } frame_pos_t;

    localparam frame_pos_t POS_LAST = '{slot_i: SLOT_IW'(SLOTS-1),
                                        byte_i: BYTE_IW'(SLOT_BYTES-1),
                                        bit_i:  BIT_IW'(BYTE_W-1)};

    function automatic logic pos_end_byte(input frame_pos_t p);
        return p.bit_i == BIT_IW'(BYTE_W-1);
    endfunction

    function automatic logic pos_end_slot(input frame_pos_t p);
        return pos_end_byte(p) && (p.byte_i == BYTE_IW'(SLOT_BYTES-1));
    endfunction

    function automatic frame_pos_t pos_advance(input frame_pos_t p);
        frame_pos_t n;
        n = p;
        if (pos_end_byte(p)) begin
            n.bit_i = '0;
            if (pos_end_slot(p)) begin
                n.byte_i = '0;
                n.slot_i = (p.slot_i == SLOT_IW'(SLOTS-1)) ? '0 : p.slot_i + 1'b1;
            end else begin
                n.byte_i = p.byte_i + 1'b1;
            end
        end else begin
            n.bit_i = p.bit_i + 1'b1;
        end
        return n;
    endfunction
endpackage

// File: rtl/tdm_byte_fifo.sv
module tdm_byte_fifo import tdm_pkg::*; #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH+1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] din,
    input  logic              pop,
    output logic [BYTE_W-1:0] dout,
    output logic [CW-1:0]     cnt,
    output logic              full
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic push_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign push_ok = push && !full;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)     rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_count_bounded_R10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    assert_no_underrun_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0));
    assert_full_blocks_write_R10: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> $stable(cnt));
endmodule

// File: rtl/tdm_bclk_div.sv
module tdm_bclk_div #(
    parameter int HALF_FAST = 1,
    parameter int HALF_SLOW = 2,
    localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST,
    localparam int HW = $clog2(HMAX+1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic div_sel,
    output logic bclk,
    output logic fall_evt
);
    logic [HW-1:0] cnt, half_m1;
    logic edge_now;

    assign half_m1  = div_sel ? HW'(HALF_SLOW-1) : HW'(HALF_FAST-1);
    assign edge_now = run && (cnt >= half_m1);
    assign fall_evt = edge_now && bclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (edge_now) begin
            cnt  <= '0;
            bclk <= ~bclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_bclk_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> !bclk);
    assert_bclk_toggles_on_count_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !edge_now) |=> $stable(bclk));
endmodule

// File: rtl/tdm_slot_serializer.sv
module tdm_slot_serializer import tdm_pkg::*; #(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_evt,
    input  logic [CW-1:0]     start_lvl,
    input  logic [CW-1:0]     fifo_cnt,
    input  logic [BYTE_W-1:0] fifo_dout,
    output logic              fifo_pop,
    output logic              run,
    output logic              fsync,
    output logic              sdata,
    output logic              udf_evt
);
    ser_state_t st;
    frame_pos_t pos, pos_n;
    logic live, live_n, starved;
    logic [BYTE_W-2:0] shreg;
    logic step, end_byte, end_slot, end_frame, have_slot, shortfall;

    assign run       = (st == SER_RUN);
    assign step      = run && fall_evt;
    assign end_byte  = pos_end_byte(pos);
    assign end_slot  = pos_end_slot(pos);
    assign end_frame = (pos == POS_LAST);
    assign pos_n     = pos_advance(pos);
    assign have_slot = (fifo_cnt >= CW'(SLOT_BYTES));
    assign live_n    = end_slot ? ((end_frame || live) && have_slot) : live;
    assign fifo_pop  = step && end_byte && live_n;
    assign shortfall = step && end_slot && (end_frame || live) && !have_slot;
    assign udf_evt   = shortfall && !starved;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SER_IDLE;
            pos     <= POS_LAST;
            live    <= 1'b0;
            starved <= 1'b0;
            shreg   <= '0;
            fsync   <= 1'b0;
            sdata   <= 1'b0;
        end else if (st == SER_IDLE) begin
            if (fifo_cnt >= start_lvl) begin
                st    <= SER_RUN;
                pos   <= POS_LAST;
                fsync <= 1'b1;
                sdata <= 1'b0;
            end
        end else if (step) begin
            pos   <= pos_n;
            live  <= live_n;
            fsync <= (pos_n == POS_LAST);
            if (end_byte) begin
                sdata <= fifo_pop ? fifo_dout[BYTE_W-1] : 1'b0;
                shreg <= fifo_pop ? fifo_dout[BYTE_W-2:0] : '0;
            end else begin
                sdata <= shreg[BYTE_W-2];
                shreg <= {shreg[BYTE_W-3:0], 1'b0};
            end
            if (shortfall)                   starved <= 1'b1;
            else if (end_frame && live_n)    starved <= 1'b0;
        end
    end

    assert_stable_between_falls_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !fall_evt) |=> ($stable(sdata) && $stable(fsync)));
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!fsync && !sdata && !fifo_pop));
    assert_hold_below_level_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && (fifo_cnt < start_lvl)) |=> !run);
    assert_zero_slot_no_pop_R8: assert property (@(posedge clk) disable iff (rst)
        shortfall |-> !fifo_pop);
endmodule

// File: rtl/tdm_dac_streamer.sv
module tdm_dac_streamer import tdm_pkg::*; #(
    parameter int DEPTH = 128,
    parameter int HALF_FAST = 1,
    parameter int HALF_SLOW = 2,
    localparam int CW = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_stb,
    input  logic [CW-1:0]     start_lvl,
    input  logic              div_sel,
    input  logic              flag_clr,
    output logic              bclk,
    output logic              fsync,
    output logic              sdata,
    output logic              underflow,
    output logic              overflow
);
    logic stb_q, push_req, fifo_full, fifo_pop, run, fall_evt, udf_evt;
    logic [BYTE_W-1:0] fifo_dout;
    logic [CW-1:0] fifo_cnt;

    assign push_req = wr_stb && !stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q     <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            stb_q <= wr_stb;
            if (push_req && fifo_full) overflow <= 1'b1;
            else if (flag_clr)         overflow <= 1'b0;
            if (udf_evt)               underflow <= 1'b1;
            else if (flag_clr)         underflow <= 1'b0;
        end
    end

    tdm_byte_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .push(push_req), .din(wr_data),
        .pop(fifo_pop), .dout(fifo_dout), .cnt(fifo_cnt), .full(fifo_full)
    );

    tdm_bclk_div #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) div_i (
        .clk(clk), .rst(rst), .run(run), .div_sel(div_sel),
        .bclk(bclk), .fall_evt(fall_evt)
    );

    tdm_slot_serializer #(.CW(CW)) ser_i (
        .clk(clk), .rst(rst), .fall_evt(fall_evt), .start_lvl(start_lvl),
        .fifo_cnt(fifo_cnt), .fifo_dout(fifo_dout), .fifo_pop(fifo_pop),
        .run(run), .fsync(fsync), .sdata(sdata), .udf_evt(udf_evt)
    );

    assert_drop_sets_ovf_R10: assert property (@(posedge clk) disable iff (rst)
        (push_req && fifo_full) |=> overflow);
    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (overflow && !flag_clr) |=> overflow);
    assert_udf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (underflow && !flag_clr) |=> underflow);
    assert_clear_works_R11: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(push_req && fifo_full)) |=> !overflow);
endmodule

// File: tb/tdm_dac_streamer_tb_top.sv
module tdm_dac_streamer_tb_top;
    localparam int DEPTH = 128;
    localparam int CW = $clog2(DEPTH+1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] wr_data = '0;
    logic wr_stb = 1'b0, div_sel = 1'b0, flag_clr = 1'b0;
    logic [CW-1:0] start_lvl = CW'(100);
    logic bclk, fsync, sdata, underflow, overflow;

    always #4 clk = ~clk;

    tdm_dac_streamer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .wr_data(wr_data), .wr_stb(wr_stb),
        .start_lvl(start_lvl), .div_sel(div_sel), .flag_clr(flag_clr),
        .bclk(bclk), .fsync(fsync), .sdata(sdata),
        .underflow(underflow), .overflow(overflow)
    );

    int errors = 0, checks = 0;
    logic [7:0] sent [256];

    // serial stream decoder, samples away from the active edge
    int cyc = 0, rises = 0, last_rise = 0, period = 0;
    int bitcnt = 0, nframes = 0, sync_err = 0, viol = 0;
    logic in_frame = 1'b0, bclk_q = 1'b0, sd_q = 1'b0, fs_q = 1'b0;
    logic [191:0] fbuf = '0;
    logic [191:0] frames [64];

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            rises = 0; bitcnt = 0; nframes = 0; sync_err = 0; viol = 0;
            in_frame = 1'b0;
        end else begin
            if (bclk && !bclk_q) begin
                rises++;
                period = cyc - last_rise;
                last_rise = cyc;
                if (in_frame) begin
                    fbuf = {fbuf[190:0], sdata};
                    bitcnt++;
                    if (bitcnt == 192) begin
                        if (nframes < 64) frames[nframes] = fbuf;
                        nframes++;
                        in_frame = 1'b0;
                    end
                end
                if (fsync) begin
                    if (in_frame) sync_err++;
                    in_frame = 1'b1;
                    bitcnt = 0;
                end
            end
            if (bclk && bclk_q && (sdata != sd_q || fsync != fs_q)) viol++;
        end
        bclk_q = bclk; sd_q = sdata; fs_q = fsync;
    end

    task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input int hi, input int lo);
        wr_data = b;
        wr_stb = 1'b1;
        repeat (hi) @(negedge clk);
        wr_stb = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic wait_frames(input int n);
        int g = 0;
        while (nframes < n && g < 20000) begin
            @(negedge clk);
            g++;
        end
    endtask

    function automatic logic [191:0] exp_frame(input int base, input int avail);
        logic [191:0] f;
        f = '0;
        for (int s = 0; s < 8; s++)
            if ((s + 1) * 3 <= avail)
                for (int b = 0; b < 3; b++)
                    f[191 - 8*(s*3 + b) -: 8] = sent[base + s*3 + b];
        return f;
    endfunction

    function automatic int first_nonzero(input int from);
        for (int i = from; i < 64; i++)
            if (i < nframes && frames[i] != '0) return i;
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int j;
        int g;
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 bclk after reset", 192'(bclk), 192'(0));
        check("R1 fsync after reset", 192'(fsync), 192'(0));
        check("R1 sdata after reset", 192'(sdata), 192'(0));
        check("R1 underflow after reset", 192'(underflow), 192'(0));
        check("R1 overflow after reset", 192'(overflow), 192'(0));

        // random bytes, strobes held two cycles (R2)
        for (int i = 0; i < 120; i++) sent[i] = 8'(($urandom % 255) + 1);
        for (int i = 0; i < 99; i++) wr_byte(sent[i], 2, 2);
        repeat (20) @(negedge clk);
        check("R3 no bit clock below start level", 192'(rises), 192'(0));
        for (int i = 99; i < 120; i++) wr_byte(sent[i], 2, 2);
        wait_frames(6);
        for (int f = 0; f < 5; f++)
            check("R2 R6 frame content", frames[f], exp_frame(24*f, 24));
        check("R8 starved frame zero", frames[5], '0);
        check("R5 sync spacing and width", 192'(sync_err), 192'(0));
        check("R4 fast bit period", 192'(period), 192'(2));
        check("R8 underflow set", 192'(underflow), 192'(1));
        check("R10 no overflow below depth", 192'(overflow), 192'(0));

        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R11 clear underflow", 192'(underflow), 192'(0));

        // resume burst at one byte per two cycles (R9)
        for (int i = 120; i < 168; i++) sent[i] = 8'(($urandom % 255) + 1);
        for (int i = 120; i < 168; i++) wr_byte(sent[i], 1, 1);
        j = -1;
        g = 0;
        while ((j < 0 || nframes < j + 3) && g < 20000) begin
            @(negedge clk);
            j = first_nonzero(6);
            g++;
        end
        if (j < 0) j = 6;
        check("R9 resume at frame boundary", frames[j], exp_frame(120, 24));
        check("R9 second resumed frame", frames[j+1], exp_frame(144, 24));
        check("R8 zeros after drain", frames[j+2], '0);
        check("R8 underflow on new shortage", 192'(underflow), 192'(1));

        // overflow with streaming held off, slow clock
        rst = 1'b1;
        div_sel = 1'b1;
        start_lvl = CW'(200);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 128; i++) sent[i] = 8'(($urandom % 255) + 1);
        for (int i = 0; i < 128; i++) wr_byte(sent[i], 1, 1);
        check("R10 full without drop", 192'(overflow), 192'(0));
        wr_byte(8'hAA, 1, 1);
        check("R10 drop sets overflow", 192'(overflow), 192'(1));
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R11 clear overflow", 192'(overflow), 192'(0));
        wr_data = 8'h55;
        wr_stb = 1'b1;
        flag_clr = 1'b1;
        @(negedge clk);
        check("R11 set wins over clear", 192'(overflow), 192'(1));
        wr_stb = 1'b0;
        flag_clr = 1'b0;
        @(negedge clk);
        check("R3 held below level", 192'(rises), 192'(0));
        start_lvl = CW'(128);
        wait_frames(7);
        for (int f = 0; f < 5; f++)
            check("R6 R10 frame after fill", frames[f], exp_frame(24*f, 24));
        check("R8 R10 partial frame", frames[5], exp_frame(120, 8));
        check("R8 following frame zero", frames[6], '0);
        check("R4 slow bit period", 192'(period), 192'(4));
        check("R7 stable while bclk high", 192'(viol), 192'(0));
        check("R5 sync spacing slow", 192'(sync_err), 192'(0));
        check("R8 underflow partial", 192'(underflow), 192'(1));

        // reset during streaming
        rst = 1'b1;
        @(negedge clk);
        check("R12 bclk low in reset", 192'(bclk), 192'(0));
        check("R12 fsync low in reset", 192'(fsync), 192'(0));
        check("R12 sdata low in reset", 192'(sdata), 192'(0));
        @(negedge clk);
        rst = 1'b0;
        div_sel = 1'b0;
        start_lvl = CW'(100);
        @(negedge clk);
        check("R12 flags cleared", 192'({underflow, overflow}), 192'(0));
        for (int i = 0; i < 5; i++) wr_byte(8'h3C, 1, 1);
        repeat (100) @(negedge clk);
        check("R12 threshold re-armed", 192'(rises), 192'(0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule